// File: doc/BRIEF.md
# Dual Conversion Queue Arbiter

This block decides which of two command queues drives a single shared analog-to-digital converter. Each queue is a list of command words that sits in its own region of a shared command memory. Each queue has its own triggers and its own command pointer. When a queue is triggered, the block fetches that queue's current command word through a synchronous read port. A normal command is handed to the converter with a one-cycle start pulse. When the converter reports done, the block moves that queue's pointer forward.

Queue 1 outranks queue 2. The arbitration decision is taken again after every conversion. A queue 1 trigger that arrives while a queue 2 conversion is running therefore takes the converter as soon as that conversion finishes. Queue 2 then picks up again at the command where it was interrupted.

A queue stops running in three ways:
- A command with its pause bit set is converted, and the queue then waits for another trigger.
- An end-of-queue code sends the queue back to idle without a conversion. In continuous mode it instead re-arms the queue from its first command.
- Finishing the last slot of the queue's region acts as an end-of-queue.

The read port must hold its data output until the next read is issued. Block RAM without an output reset meets this.

Top module: `dcq_arbiter_top`

## Requirements
- R1: After reset both queues report idle (code 0), and neither `conv_start` nor `cmd_rd_en` is asserted.
- R2: A queue leaves idle on its software trigger pulse or on a rising edge of its external trigger (synchronised through two flops). It then starts at its first command: address 0 for queue 1 and address DEPTH for queue 2.
- R3: While `q2_tmr_en` is high, queue 2 is triggered once every TMR_PERIOD clock cycles.
- R4: `conv_start` is a one-cycle pulse, issued only while `conv_busy` is low, with at most one conversion outstanding. `conv_qid` is 0 for queue 1 and 1 for queue 2, and `conv_chan` carries the command's channel.
- R5: When both queues are ready, queue 1 is served first. A queue 1 trigger during a queue 2 conversion takes the next conversion.
- R6: A queue 2 run that queue 1 interrupts resumes at the command that follows its last converted one.
- R7: A command word is CH_W+1 bits wide. Bits [CH_W-1:0] are the channel and bit CH_W is the pause bit. A command with the pause bit set is converted, and the queue then enters paused (code 3). The next trigger resumes it at the following command, and only a trigger leads out of pause.
- R8: A channel field of all ones is end-of-queue. In single-scan mode it returns the queue to idle without a conversion, and the next trigger starts again from the first command.
- R9: With the queue's continuous input high, end-of-queue re-arms the queue at its first command with no trigger. Clearing the input ends the run at the next end-of-queue.
- R10: After the command in the last slot of a queue's region (index DEPTH-1) is converted, the queue ends as on end-of-queue.
- R11: A trigger that arrives while a queue is ready or converting has no effect on its sequence of conversions.
- R12: The status codes are 0 idle, 1 triggered/ready, 2 converting (from selection until done), and 3 paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q1_ext_trig | input | 1 | Queue 1 external trigger, asynchronous, rising edge |
| q1_sw_trig | input | 1 | Queue 1 software single-scan trigger pulse |
| q1_cont | input | 1 | Queue 1 continuous mode |
| q2_ext_trig | input | 1 | Queue 2 external trigger, asynchronous, rising edge |
| q2_sw_trig | input | 1 | Queue 2 software single-scan trigger pulse |
| q2_cont | input | 1 | Queue 2 continuous mode |
| q2_tmr_en | input | 1 | Enables the queue 2 interval timer |
| cmd_rd_en | output | 1 | Command memory read enable |
| cmd_rd_addr | output | $clog2(DEPTH)+1 | Command memory read address |
| cmd_rd_data | input | CH_W+1 | Command word, valid the cycle after the read |
| conv_start | output | 1 | Converter start pulse |
| conv_chan | output | CH_W | Channel to convert |
| conv_qid | output | 1 | Queue that owns the conversion |
| conv_busy | input | 1 | Converter busy |
| conv_done | input | 1 | Converter done pulse |
| q1_state | output | 2 | Queue 1 status code |
| q2_state | output | 2 | Queue 2 status code |

## Verification
The assertions check the following on every cycle:
- The converter handshake: start is a single pulse, never issued while busy, and only for a queue that reports converting.
- The two queues are never converting together.
- Idle and paused queues leave only towards ready.

Only the directed scenarios can show the ordering behaviour, because it depends on the command words in memory and on when triggers land. This covers queue 1 preempting queue 2 between conversions, queue 2 resuming at the right command, and the pause, end-of-queue, continuous-loop and last-slot endings. It also covers the timer spacing and the ignored retriggers.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
  typedef enum logic [1:0] {
    QS_IDLE   = 2'd0,
    QS_READY  = 2'd1,
    QS_CONV   = 2'd2,
    QS_PAUSED = 2'd3
  } qstate_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_DECODE,
    SQ_WAIT
  } seq_e;
endpackage

// File: rtl/dcq_trig_sync.sv
module dcq_trig_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic pulse
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign pulse = s2 & ~s3;
endmodule

// File: rtl/dcq_interval_timer.sv
module dcq_interval_timer #(
  parameter int PERIOD = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic expire
);
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else if (!en) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else if (cnt == LAST) begin
      cnt    <= '0;
      expire <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      expire <= 1'b0;
    end
  end
endmodule

// File: rtl/dcq_queue_ctrl.sv
module dcq_queue_ctrl
  import dcq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic             cont,
  input  logic             grant,
  input  logic             done,
  input  logic             pause,
  input  logic             eoq,
  output qstate_e          state,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic end_run;
  assign end_run = eoq | (done & (idx == LAST_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= QS_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        QS_IDLE: begin
          if (trig) begin
            state <= QS_READY;
            idx   <= '0;
          end
        end
        QS_PAUSED: begin
          if (trig) state <= QS_READY;
        end
        QS_READY: begin
          if (grant) state <= QS_CONV;
        end
        QS_CONV: begin
          if (end_run) begin
            idx   <= '0;
            state <= cont ? QS_READY : QS_IDLE;
          end else if (done) begin
            idx   <= idx + 1'b1;
            state <= pause ? QS_PAUSED : QS_READY;
          end
        end
        default: state <= QS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcq_sequencer.sv
module dcq_sequencer
  import dcq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CH_W  = 6,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + 1,
  localparam int CMD_W  = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        q_ready,
  input  logic [IDX_W-1:0]  idx0,
  input  logic [IDX_W-1:0]  idx1,
  output logic [1:0]        grant,
  output logic [1:0]        done,
  output logic [1:0]        eoq,
  output logic              pause_out,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [CMD_W-1:0]  rd_data,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  output logic              conv_qid,
  input  logic              conv_busy,
  input  logic              conv_done
);
  localparam logic [CH_W-1:0] EOQ_CODE = {CH_W{1'b1}};

  seq_e st;
  logic sel;
  logic pause_l;
  logic is_eoq;

  assign is_eoq = (rd_data[CH_W-1:0] == EOQ_CODE);

  always_comb begin
    grant[0] = (st == SQ_IDLE) & q_ready[0];
    grant[1] = (st == SQ_IDLE) & ~q_ready[0] & q_ready[1];
    for (int i = 0; i < 2; i++) begin
      eoq[i]  = (st == SQ_DECODE) & is_eoq & (sel == i[0]);
      done[i] = (st == SQ_WAIT) & conv_done & (sel == i[0]);
    end
  end

  assign pause_out = pause_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      sel        <= 1'b0;
      pause_l    <= 1'b0;
      rd_en      <= 1'b0;
      rd_addr    <= '0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      conv_qid   <= 1'b0;
    end else begin
      rd_en      <= 1'b0;
      conv_start <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (|q_ready) begin
            sel     <= ~q_ready[0];
            rd_en   <= 1'b1;
            rd_addr <= q_ready[0] ? {1'b0, idx0} : {1'b1, idx1};
            st      <= SQ_FETCH;
          end
        end
        SQ_FETCH: st <= SQ_DECODE;
        SQ_DECODE: begin
          if (is_eoq) begin
            st <= SQ_IDLE;
          end else if (!conv_busy) begin
            conv_start <= 1'b1;
            conv_chan  <= rd_data[CH_W-1:0];
            conv_qid   <= sel;
            pause_l    <= rd_data[CH_W];
            st         <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (conv_done) st <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcq_arbiter_top.sv
module dcq_arbiter_top
  import dcq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int CH_W       = 6,
  parameter int TMR_PERIOD = 1000,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + 1,
  localparam int CMD_W  = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q1_ext_trig,
  input  logic              q1_sw_trig,
  input  logic              q1_cont,
  input  logic              q2_ext_trig,
  input  logic              q2_sw_trig,
  input  logic              q2_cont,
  input  logic              q2_tmr_en,
  output logic              cmd_rd_en,
  output logic [ADDR_W-1:0] cmd_rd_addr,
  input  logic [CMD_W-1:0]  cmd_rd_data,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  output logic              conv_qid,
  input  logic              conv_busy,
  input  logic              conv_done,
  output logic [1:0]        q1_state,
  output logic [1:0]        q2_state
);
  logic [1:0]       ext_in, ext_pulse, sw_in, cont_in, trig;
  logic [1:0]       grant, done, eoq, ready;
  logic             pause;
  logic             tmr_expire;
  qstate_e          qst [2];
  logic [IDX_W-1:0] qidx [2];

  assign ext_in  = {q2_ext_trig, q1_ext_trig};
  assign sw_in   = {q2_sw_trig, q1_sw_trig};
  assign cont_in = {q2_cont, q1_cont};

  dcq_interval_timer #(.PERIOD(TMR_PERIOD)) u_tmr (
    .clk(clk), .rst(rst), .en(q2_tmr_en), .expire(tmr_expire)
  );

  for (genvar g = 0; g < 2; g++) begin : g_q
    dcq_trig_sync u_sync (
      .clk(clk), .rst(rst), .async_in(ext_in[g]), .pulse(ext_pulse[g])
    );

    if (g == 1) begin : g_tmr
      assign trig[g] = ext_pulse[g] | sw_in[g] | tmr_expire;
    end else begin : g_notmr
      assign trig[g] = ext_pulse[g] | sw_in[g];
    end

    dcq_queue_ctrl #(.DEPTH(DEPTH)) u_qc (
      .clk(clk), .rst(rst), .trig(trig[g]), .cont(cont_in[g]),
      .grant(grant[g]), .done(done[g]), .pause(pause), .eoq(eoq[g]),
      .state(qst[g]), .idx(qidx[g])
    );

    assign ready[g] = (qst[g] == QS_READY);
  end

  dcq_sequencer #(.DEPTH(DEPTH), .CH_W(CH_W)) u_seq (
    .clk(clk), .rst(rst), .q_ready(ready), .idx0(qidx[0]), .idx1(qidx[1]),
    .grant(grant), .done(done), .eoq(eoq), .pause_out(pause),
    .rd_en(cmd_rd_en), .rd_addr(cmd_rd_addr), .rd_data(cmd_rd_data),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_qid(conv_qid),
    .conv_busy(conv_busy), .conv_done(conv_done)
  );

  assign q1_state = qst[0];
  assign q2_state = qst[1];
endmodule

// File: rtl/dcq_checker.sv
module dcq_checker (
  input logic       clk,
  input logic       rst,
  input logic       conv_start,
  input logic       conv_qid,
  input logic       conv_busy,
  input logic       cmd_rd_en,
  input logic [1:0] q1_state,
  input logic [1:0] q2_state
);
  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(!conv_busy)); // R4
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start); // R4
  AST_SINGLE_CONV: assert property (@(posedge clk) disable iff (rst)
    !(q1_state == 2'd2 && q2_state == 2'd2)); // R4
  AST_START_OWNER: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> ((conv_qid ? q2_state : q1_state) == 2'd2)); // R12
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_rd_en |=> !cmd_rd_en); // R4
  AST_Q1_IDLE_EXIT: assert property (@(posedge clk) disable iff (rst)
    (q1_state == 2'd0) |=> (q1_state == 2'd0 || q1_state == 2'd1)); // R2
  AST_Q2_IDLE_EXIT: assert property (@(posedge clk) disable iff (rst)
    (q2_state == 2'd0) |=> (q2_state == 2'd0 || q2_state == 2'd1)); // R2
  AST_Q1_PAUSE_EXIT: assert property (@(posedge clk) disable iff (rst)
    (q1_state == 2'd3) |=> (q1_state == 2'd3 || q1_state == 2'd1)); // R7
  AST_Q2_PAUSE_EXIT: assert property (@(posedge clk) disable iff (rst)
    (q2_state == 2'd3) |=> (q2_state == 2'd3 || q2_state == 2'd1)); // R7
endmodule

bind dcq_arbiter_top dcq_checker u_chk (
  .clk(clk), .rst(rst), .conv_start(conv_start), .conv_qid(conv_qid),
  .conv_busy(conv_busy), .cmd_rd_en(cmd_rd_en),
  .q1_state(q1_state), .q2_state(q2_state)
);

// File: tb/tb_dcq_arbiter_top.sv
module tb_dcq_arbiter_top;
  localparam int DEPTH = 8;
  localparam int CH_W  = 6;
  localparam int TMR   = 40;
  localparam int LAT   = 6;
  localparam logic [6:0] EOQ = 7'h3F;
  localparam logic [6:0] PB  = 7'h40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic q1_ext_trig = 0, q1_sw_trig = 0, q1_cont = 0;
  logic q2_ext_trig = 0, q2_sw_trig = 0, q2_cont = 0, q2_tmr_en = 0;
  logic cmd_rd_en;
  logic [3:0] cmd_rd_addr;
  logic [6:0] cmd_rd_data = '0;
  logic conv_start;
  logic [5:0] conv_chan;
  logic conv_qid;
  logic conv_busy = 0, conv_done = 0;
  logic [1:0] q1_state, q2_state;

  logic [6:0] mem [2*DEPTH];
  int log_ch [256];
  int log_q  [256];
  int log_t  [256];
  int n = 0;
  int cyc = 0;
  int cnt = 0;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dcq_arbiter_top #(.DEPTH(DEPTH), .CH_W(CH_W), .TMR_PERIOD(TMR)) dut (
    .clk(clk), .rst(rst),
    .q1_ext_trig(q1_ext_trig), .q1_sw_trig(q1_sw_trig), .q1_cont(q1_cont),
    .q2_ext_trig(q2_ext_trig), .q2_sw_trig(q2_sw_trig), .q2_cont(q2_cont),
    .q2_tmr_en(q2_tmr_en),
    .cmd_rd_en(cmd_rd_en), .cmd_rd_addr(cmd_rd_addr), .cmd_rd_data(cmd_rd_data),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_qid(conv_qid),
    .conv_busy(conv_busy), .conv_done(conv_done),
    .q1_state(q1_state), .q2_state(q2_state)
  );

  always @(posedge clk) if (cmd_rd_en) cmd_rd_data <= mem[cmd_rd_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model and start logger, away from the active edge
  always @(negedge clk) begin
    cyc++;
    conv_done <= 1'b0;
    if (!rst && conv_start) begin
      chk(!conv_busy, "R4 start while busy", conv_busy, 0);
      if (n < 256) begin
        log_ch[n] = conv_chan;
        log_q[n]  = conv_qid;
        log_t[n]  = cyc;
      end
      n++;
      conv_busy <= 1'b1;
      cnt = LAT;
    end else if (conv_busy) begin
      cnt--;
      if (cnt == 0) begin
        conv_busy <= 1'b0;
        conv_done <= 1'b1;
      end
    end
  end

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic sw1();
    @(negedge clk) q1_sw_trig = 1;
    @(negedge clk) q1_sw_trig = 0;
  endtask

  task automatic sw2();
    @(negedge clk) q2_sw_trig = 1;
    @(negedge clk) q2_sw_trig = 0;
  endtask

  task automatic wait_n(input int target);
    for (int k = 0; k < 2000 && n < target; k++) @(negedge clk);
  endtask

  task automatic expect_seq(input int base, input int len, input int chs [16],
                            input int qs [16], input string req);
    chk(n - base == len, {req, " start count"}, n - base, len);
    for (int i = 0; i < len && base + i < n; i++) begin
      chk(log_ch[base+i] == chs[i], {req, " channel"}, log_ch[base+i], chs[i]);
      chk(log_q[base+i] == qs[i], {req, " queue id"}, log_q[base+i], qs[i]);
    end
  endtask

  task automatic t_reset();
    chk(q1_state == 0, "R1 q1 idle", q1_state, 0);
    chk(q2_state == 0, "R1 q2 idle", q2_state, 0);
    chk(conv_start == 0, "R1 no start", conv_start, 0);
    chk(cmd_rd_en == 0, "R1 no read", cmd_rd_en, 0);
  endtask

  task automatic t_single_eoq();
    int b;
    mem[0] = 7'd1; mem[1] = 7'd2; mem[2] = 7'd3; mem[3] = EOQ;
    b = n; sw1(); idle(200);
    expect_seq(b, 3, '{1,2,3,0,0,0,0,0,0,0,0,0,0,0,0,0}, '{default:0}, "R2 R8 sw scan");
    chk(q1_state == 0, "R8 R12 idle after eoq", q1_state, 0);
    b = n;
    @(negedge clk) q1_ext_trig = 1;
    idle(3);
    q1_ext_trig = 0;
    idle(200);
    expect_seq(b, 3, '{1,2,3,0,0,0,0,0,0,0,0,0,0,0,0,0}, '{default:0}, "R2 R8 ext restart");
  endtask

  task automatic t_pause();
    int b;
    mem[0] = 7'd4; mem[1] = PB | 7'd5; mem[2] = 7'd6; mem[3] = EOQ;
    b = n; sw1(); idle(200);
    expect_seq(b, 2, '{4,5,0,0,0,0,0,0,0,0,0,0,0,0,0,0}, '{default:0}, "R7 pause stop");
    chk(q1_state == 3, "R7 R12 paused code", q1_state, 3);
    b = n; sw1(); idle(200);
    expect_seq(b, 1, '{6,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0}, '{default:0}, "R7 resume next");
    chk(q1_state == 0, "R7 idle after resume", q1_state, 0);
  endtask

  task automatic t_priority();
    int b;
    mem[0] = 7'd20; mem[1] = 7'd21; mem[2] = EOQ;
    mem[8] = 7'd10; mem[9] = 7'd11; mem[10] = 7'd12; mem[11] = 7'd13; mem[12] = EOQ;
    b = n; sw2(); wait_n(b + 2); sw1();
    chk(q2_state == 2, "R12 q2 converting", q2_state, 2);
    chk(q1_state == 1, "R12 q1 ready", q1_state, 1);
    idle(300);
    expect_seq(b, 6, '{10,11,20,21,12,13,0,0,0,0,0,0,0,0,0,0},
               '{1,1,0,0,1,1,0,0,0,0,0,0,0,0,0,0}, "R5 R6 preempt resume");
    b = n;
    @(negedge clk) begin q1_sw_trig = 1; q2_sw_trig = 1; end
    @(negedge clk) begin q1_sw_trig = 0; q2_sw_trig = 0; end
    idle(300);
    expect_seq(b, 6, '{20,21,10,11,12,13,0,0,0,0,0,0,0,0,0,0},
               '{0,0,1,1,1,1,0,0,0,0,0,0,0,0,0,0}, "R5 both ready");
  endtask

  task automatic t_ignore();
    int b;
    mem[0] = 7'd30; mem[1] = 7'd31; mem[2] = 7'd32; mem[3] = EOQ;
    b = n; sw1(); sw1();
    wait_n(b + 1); sw1();
    wait_n(b + 2);
    @(negedge clk) q1_ext_trig = 1;
    idle(3);
    q1_ext_trig = 0;
    idle(300);
    expect_seq(b, 3, '{30,31,32,0,0,0,0,0,0,0,0,0,0,0,0,0}, '{default:0}, "R11 retrigger ignored");
    chk(q1_state == 0, "R11 idle at end", q1_state, 0);
  endtask

  task automatic t_cont();
    int b;
    mem[0] = 7'd40; mem[1] = 7'd41; mem[2] = EOQ;
    q1_cont = 1;
    b = n; sw1(); wait_n(b + 5);
    q1_cont = 0;
    idle(300);
    expect_seq(b, 6, '{40,41,40,41,40,41,0,0,0,0,0,0,0,0,0,0}, '{default:0}, "R9 continuous loop");
    chk(q1_state == 0, "R9 stops when cleared", q1_state, 0);
  endtask

  task automatic t_last();
    int b;
    for (int i = 0; i < DEPTH; i++) mem[DEPTH+i] = 7'(50 + i);
    b = n; sw2(); idle(400);
    expect_seq(b, 8, '{50,51,52,53,54,55,56,57,0,0,0,0,0,0,0,0},
               '{1,1,1,1,1,1,1,1,0,0,0,0,0,0,0,0}, "R10 last slot");
    chk(q2_state == 0, "R10 idle after last", q2_state, 0);
  endtask

  task automatic t_timer();
    int b;
    mem[8] = 7'd60; mem[9] = EOQ;
    b = n;
    @(negedge clk) q2_tmr_en = 1;
    idle(3 * TMR + 10);
    q2_tmr_en = 0;
    idle(100);
    chk(n - b == 3, "R3 timer trigger count", n - b, 3);
    for (int i = 1; i < 3 && b + i < n; i++)
      chk(log_t[b+i] - log_t[b+i-1] == TMR, "R3 timer spacing",
          log_t[b+i] - log_t[b+i-1], TMR);
    if (n > b) chk(log_ch[b] == 60 && log_q[b] == 1, "R3 timer queue 2", log_ch[b], 60);
  endtask

  initial begin
    for (int i = 0; i < 2*DEPTH; i++) mem[i] = EOQ;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_single_eoq();
    t_pause();
    t_priority();
    t_ignore();
    t_cont();
    t_last();
    t_timer();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule